// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers single-cycle event pulses from a set of sources into a sticky pending register and drives one active-low interrupt line toward a host processor. A second register chooses which sources are allowed to pull that line. The line behaves as a level: it stays low for as long as any pending bit whose source is allowed remains set.

The host reaches both registers through a simple synchronous register port: a write strobe, an address, write data and combinational read data. The pending register sits at address 10 and the mask register at address 11. The host's service routine reads the pending register and acknowledges events by writing zeros into the bits it has handled. Ones in that write leave their bits untouched. The serial bus that carries these accesses and the logic that produces the events lie outside the block.

Top module: `evirq_ctrl`

## Requirements
- R1: After reset the pending register and the mask register read as zero and irq_n_o is 1.
- R2: A 1 on evt_i[i] in a cycle sets pending bit i at the next clock edge, whatever the value of mask bit i. Bit i of the register at address 10 reads that pending bit.
- R3: A write to address 10 clears every pending bit whose write-data bit is 0 and leaves unchanged every pending bit whose write-data bit is 1.
- R4: When evt_i[i] is 1 in the same cycle as a write to address 10 with data bit i equal to 0, pending bit i is 1 after that edge.
- R5: A write to address 11 loads mask bit i from write-data bit i, and a read of address 11 returns it. Mask bit i lets source i drive the line, and bit 0 belongs to the pushbutton source in both registers.
- R6: irq_n_o is registered. It goes to 0 at the clock edge after the edge at which some bit is set in both the pending register and the mask register, which is two edges after the event pulse when the mask bit is already set.
- R7: irq_n_o stays 0 while any pending bit with its mask bit set remains 1. It returns to 1 at the edge after the last such bit is cleared or masked.
- R8: Pending bits whose mask bit is 0 never pull irq_n_o low. Setting the mask bit of an already-pending bit asserts the line.
- R9: Writes to any address other than 10 and 11 change neither register. Reads of such addresses, and read-data bits at or above the number of sources, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Event pulses, one per source, bit 0 the pushbutton |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| irq_n_o | output | 1 | Active-low level interrupt to the host |

## Verification
The bench builds the block with five sources on an eight-bit data path. The three top data bits therefore have no source behind them, and R9's zero readback of bits past the source count can be checked. The default address width of eight bits covers both register addresses and a spare address that is used for the ignored-write and zero-read cases. Five sources are enough to clear several bits in one write while others are kept, to race an event against a clear, and to hold the line low through a partial acknowledge.

// File: rtl/evirq_pkg.sv
package evirq_pkg;

    // Which register an access selects
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2
    } evirq_sel_e;

    localparam int unsigned PENDING_ADDR_DEF = 10;
    localparam int unsigned MASK_ADDR_DEF    = 11;

endpackage

// File: rtl/evirq_status.sv
module evirq_status #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               ack_wr_i,
    input  logic [NUM_SRC-1:0] ack_keep_i,
    output logic [NUM_SRC-1:0] pend_q_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            // a zero in the acknowledge write drops the bit; a new event wins
            if (ack_wr_i && !ack_keep_i[i])
                st_d.pend[i] = 1'b0;
            if (evt_i[i])
                st_d.pend[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q_o = st_q.pend;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit_chk
        // R2 R4
        evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> pend_q_o[g]);
        // R3
        keep_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_wr_i && ack_keep_i[g] && pend_q_o[g]) |=> pend_q_o[g]);
        // R2
        rise_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q_o[g]) |-> $past(evt_i[g]));
    end

endmodule

// File: rtl/evirq_regport.sv
module evirq_regport
    import evirq_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PEND_ADDR  = PENDING_ADDR_DEF,
    parameter int unsigned MASK_ADDR  = MASK_ADDR_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0] mask_q_o,
    output logic               ack_wr_o,
    output logic [NUM_SRC-1:0] ack_keep_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_ADDR);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } rp_t;

    rp_t        rp_d, rp_q;
    evirq_sel_e sel;

    always_comb begin
        if (addr_i == PEND_A)      sel = SEL_STATUS;
        else if (addr_i == MASK_A) sel = SEL_MASK;
        else                       sel = SEL_NONE;
    end

    always_comb begin
        rp_d = rp_q;
        if (wr_i && sel == SEL_MASK)
            rp_d.mask = wdata_i[NUM_SRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    always_comb begin
        case (sel)
            SEL_STATUS: rdata_o = DATA_W'(pend_i);
            SEL_MASK:   rdata_o = DATA_W'(rp_q.mask);
            default:    rdata_o = '0;
        endcase
    end

    assign mask_q_o   = rp_q.mask;
    assign ack_wr_o   = wr_i && (sel == SEL_STATUS);
    assign ack_keep_o = wdata_i[NUM_SRC-1:0];

    // R9
    other_addr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i != MASK_A) |=> $stable(mask_q_o));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == MASK_A) |=> mask_q_o == $past(wdata_i[NUM_SRC-1:0]));

endmodule

// File: rtl/evirq_line.sv
module evirq_line #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               irq_n_o
);

    typedef struct packed {
        logic irq_n;
    } ln_t;

    ln_t ln_d, ln_q;

    always_comb begin
        ln_d       = ln_q;
        ln_d.irq_n = ~|(pend_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '{irq_n: 1'b1};
        else        ln_q <= ln_d;
    end

    assign irq_n_o = ln_q.irq_n;

    // R6 R7
    line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & mask_i) != '0) |=> !irq_n_o);

    // R8
    line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & mask_i) == '0) |=> irq_n_o);

endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl
    import evirq_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PEND_ADDR = PENDING_ADDR_DEF,
    parameter int unsigned MASK_ADDR = MASK_ADDR_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_n_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               ack_wr;
    logic [NUM_SRC-1:0] ack_keep;

    evirq_regport #(
        .NUM_SRC  (NUM_SRC),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PEND_ADDR(PEND_ADDR),
        .MASK_ADDR(MASK_ADDR)
    ) i_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .pend_i    (pend_q),
        .mask_q_o  (mask_q),
        .ack_wr_o  (ack_wr),
        .ack_keep_o(ack_keep),
        .rdata_o   (reg_rdata_o)
    );

    evirq_status #(
        .NUM_SRC(NUM_SRC)
    ) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .ack_wr_i  (ack_wr),
        .ack_keep_i(ack_keep),
        .pend_q_o  (pend_q)
    );

    evirq_line #(
        .NUM_SRC(NUM_SRC)
    ) i_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_q),
        .mask_i (mask_q),
        .irq_n_o(irq_n_o)
    );

    initial begin
        // R9
        src_fit_chk: assert (NUM_SRC >= 1 && NUM_SRC <= DATA_W);
    end

endmodule

// File: tb/test_evirq_ctrl.sv
`timescale 1ns/1ps
module test_evirq_ctrl;

    localparam int NSRC = 5;
    localparam int AW   = 8;
    localparam int DW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt = '0;
    logic            wr = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    evirq_ctrl #(.NUM_SRC(NSRC), .ADDR_W(AW), .DATA_W(DW)) i_evirq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .reg_wr_i   (wr),
        .reg_addr_i (addr),
        .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .irq_n_o    (irq_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic wrr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        evt = m;
        tick();
        evt = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        rd(8'd10, d); chk("R1 pending after reset", d, 0);
        rd(8'd11, d); chk("R1 mask after reset", d, 0);
        chk("R1 irq_n after reset", irq_n, 1);
    endtask

    task automatic t_latch();
        logic [DW-1:0] d;
        pulse(5'b00101);
        rd(8'd10, d); chk("R2 latch with mask off", d, 8'h05);
        tick();
        chk("R8 masked pending keeps line high", irq_n, 1);
        pulse(5'b10000);
        rd(8'd10, d); chk("R2 second event accumulates", d, 8'h15);
    endtask

    task automatic t_clear();
        logic [DW-1:0] d;
        wrr(8'd10, 8'hFB);
        rd(8'd10, d); chk("R3 clear bit 2 keep others", d, 8'h11);
        wrr(8'd10, 8'h00);
        rd(8'd10, d); chk("R3 clear all", d, 8'h00);
    endtask

    task automatic t_race();
        logic [DW-1:0] d;
        pulse(5'b00011);
        addr = 8'd10; wdata = 8'h00; wr = 1'b1; evt = 5'b00010;
        tick();
        wr = 1'b0; evt = '0;
        rd(8'd10, d); chk("R4 event beats clear", d, 8'h02);
        wrr(8'd10, 8'h00);
        rd(8'd10, d); chk("R4 cleanup", d, 8'h00);
    endtask

    task automatic t_mask();
        logic [DW-1:0] d;
        wrr(8'd11, 8'hFF);
        rd(8'd11, d); chk("R5 mask readback upper zero", d, 8'h1F);
        wrr(8'd11, 8'h01);
        rd(8'd11, d); chk("R5 mask pushbutton only", d, 8'h01);
    endtask

    task automatic t_line();
        logic [DW-1:0] d;
        // mask = bit0 (pushbutton), bit 3 also
        wrr(8'd11, 8'h09);
        evt = 5'b00001;
        tick();
        evt = '0;
        chk("R6 line not yet low after one edge", irq_n, 1);
        tick();
        chk("R6 line low two edges after event", irq_n, 0);
        pulse(5'b01000);
        wrr(8'd10, 8'hFE);
        tick();
        chk("R7 line held by remaining bit", irq_n, 0);
        wrr(8'd10, 8'h00);
        chk("R7 line still low at clearing edge", irq_n, 0);
        tick();
        chk("R7 line released after last clear", irq_n, 1);
        rd(8'd10, d); chk("R7 pending empty", d, 0);
    endtask

    task automatic t_late_enable();
        pulse(5'b00100);
        tick();
        chk("R8 masked bit ignored by line", irq_n, 1);
        wrr(8'd11, 8'h04);
        tick();
        chk("R8 enabling pending bit asserts line", irq_n, 0);
        wrr(8'd11, 8'h00);
        tick();
        chk("R7 masking releases line", irq_n, 1);
        wrr(8'd10, 8'h00);
    endtask

    task automatic t_other();
        logic [DW-1:0] d;
        wrr(8'd11, 8'h03);
        pulse(5'b00010);
        wrr(8'd12, 8'h00);
        wrr(8'd9, 8'h00);
        rd(8'd10, d); chk("R9 pending unchanged by other writes", d, 8'h02);
        rd(8'd11, d); chk("R9 mask unchanged by other writes", d, 8'h03);
        rd(8'd12, d); chk("R9 other address reads zero", d, 0);
        rd(8'd10, d);
    endtask

    initial begin
        #12;
        rst_n = 1'b1;
        tick();
        t_reset();
        t_latch();
        t_clear();
        t_race();
        t_mask();
        t_line();
        t_late_enable();
        t_other();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule